// File: doc/BRIEF.md
# Video Timing Shadow Register and Resync Controller

This block keeps the configuration of a video timing generator in two layers. Software writes land in a staged copy. The copy the timing logic actually uses changes only at a line boundary, and only while software has not raised an update-inhibit bit. This lets a full set of settings be loaded over several writes and then switched over at once, on a clean boundary. The block also runs the horizontal and vertical counters. In master mode an external SYNC pulse can restart them, and while the pulse is low the clock outputs can be frozen. In slave mode the counters are realigned from incoming VD and HD strobes, with a fixed latency.

Configuration enters through a valid/ready write port. `cfg_ready` is tied high, so the port never applies back-pressure: a write is taken on every rising clock edge at which `cfg_valid` is high. SYNC, VD and HD are asynchronous inputs and idle high. The outputs are the committed configuration, the two counter values and one enable bit, `clk_gate_en`, which the clock-waveform logic downstream uses to gate all of its outputs.

Top module: `vtiming_shadow_ctl`

## Requirements
- R1: While the run bit (address 0, bit 0) is 0, `h_cnt` and `v_cnt` read 0 from the edge after it is cleared, `clk_gate_en` is 0, and no commit takes place, including on an HD falling edge.
- R2: While running in master mode, `h_cnt` counts up by one per clock. When it equals the committed line length it returns to 0 on the next edge and `v_cnt` advances by one. When `v_cnt` equals the committed field length, that same edge returns it to 0 instead.
- R3: `cfg_ready` is always 1. A write at address A with data D takes effect on the edge where `cfg_valid` is high. The map is: 0 run, 1 update inhibit, 2 sync enable, 3 sync suspend and 7 slave mode, each bit 0 and each acting from the next cycle; 4 output enable (bit 0), 5 line length and 6 field length (12 bits each), these three staged. All register bits reset to 0. The reset value of each staged length is set by a parameter.
- R4: While update inhibit is 1, no staged value reaches the committed outputs, even across line boundaries.
- R5: In master mode, with inhibit 0, the staged values are committed on the edge where `h_cnt` wraps to 0, so they become visible in the same cycle that `h_cnt` reads 0.
- R6: `clk_gate_en` equals committed output enable AND run AND NOT suspended. A write to output enable changes nothing until it is committed.
- R7: With sync enable 0, SYNC has no effect on the counters or on `clk_gate_en`.
- R8: In master mode with sync enable 1, a rising edge on SYNC resets `h_cnt` and `v_cnt` to 0 on the third clock edge after the input changes. This is two synchronizer stages plus one edge-detect stage.
- R9: With sync enable and sync suspend both 1, a SYNC falling edge drives `clk_gate_en` to 0 on the third edge after the input falls. It stays 0 until the third edge after SYNC rises. With sync suspend 0, `clk_gate_en` is not affected by SYNC.
- R10: In slave mode, a VD falling edge arms the H reset. At the next HD falling edge, `h_cnt` and `v_cnt` read 0 on the tenth edge after HD falls at the input, that is 8 edges after the synchronized HD goes low. An HD falling edge that is not armed leaves the counters free-running.
- R11: In slave mode, a commit happens on the third edge after an HD falling edge at the input, and never at a counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Write request |
| cfg_ready | output | 1 | Write accepted (always 1) |
| cfg_addr | input | 3 | Register address |
| cfg_data | input | 12 | Write data |
| sync_in | input | 1 | External SYNC, asynchronous |
| vd_in | input | 1 | Vertical strobe input for slave mode |
| hd_in | input | 1 | Horizontal strobe input for slave mode |
| act_out_en | output | 1 | Committed output enable |
| act_line_len | output | 12 | Committed line length (last H count) |
| act_field_len | output | 12 | Committed field length (last V count) |
| h_cnt | output | 12 | Horizontal counter |
| v_cnt | output | 12 | Vertical counter |
| clk_gate_en | output | 1 | Gate for all downstream clock outputs |

## Verification
A commit gate that leaks would let a staged length show on `act_line_len` while the inhibit bit is still set, or in the wrong cycle relative to `h_cnt` returning to 0. That is visible within one line. A stuck or mis-set suspend flag, or a synchronizer chain of the wrong depth, shifts the change on `clk_gate_en` or the counter reset by one or more cycles away from the third edge after the input moves. The slave delay counter shows its faults in the exact cycle in which `h_cnt` reads 0 after HD. Each check therefore samples the cycle just before and the cycle of the expected change.

// File: rtl/vts_pkg.sv
package vts_pkg;
  localparam int CW = 12;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_RUN    = 3'd0,
    A_HOLD   = 3'd1,
    A_SYNCEN = 3'd2,
    A_SUSP   = 3'd3,
    A_OUTEN  = 3'd4,
    A_LINE   = 3'd5,
    A_FIELD  = 3'd6,
    A_SLAVE  = 3'd7
  } addr_e;

  typedef struct packed {
    logic          out_en;
    logic [CW-1:0] line_len;
    logic [CW-1:0] field_len;
  } vcfg_t;

  typedef struct packed {
    logic run;
    logic hold;
    logic sync_en;
    logic susp_en;
    logic slave;
  } ctl_t;
endpackage

// File: rtl/vts_in_sync.sv
module vts_in_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic s1, s2, s3;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1 <= 1'b1;
          s2 <= 1'b1;
          s3 <= 1'b1;
        end else begin
          s1 <= async_i[i];
          s2 <= s1;
          s3 <= s2;
        end
      end
      assign cur_o[i]  = s2;
      assign prev_o[i] = s3;
    end
  endgenerate
endmodule

// File: rtl/vts_cfg_bank.sv
module vts_cfg_bank
  import vts_pkg::*;
#(
  parameter logic [CW-1:0] DEF_LINE_LEN  = 12'd799,
  parameter logic [CW-1:0] DEF_FIELD_LEN = 12'd524
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          commit_i,
  output ctl_t          ctl_o,
  output vcfg_t         act_o
);
  ctl_t  ctl_q;
  vcfg_t stage_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q             <= '0;
      stage_q.out_en    <= 1'b0;
      stage_q.line_len  <= DEF_LINE_LEN;
      stage_q.field_len <= DEF_FIELD_LEN;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_RUN:    ctl_q.run         <= wr_data[0];
        A_HOLD:   ctl_q.hold        <= wr_data[0];
        A_SYNCEN: ctl_q.sync_en     <= wr_data[0];
        A_SUSP:   ctl_q.susp_en     <= wr_data[0];
        A_SLAVE:  ctl_q.slave       <= wr_data[0];
        A_OUTEN:  stage_q.out_en    <= wr_data[0];
        A_LINE:   stage_q.line_len  <= wr_data;
        A_FIELD:  stage_q.field_len <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q.out_en    <= 1'b0;
      act_q.line_len  <= DEF_LINE_LEN;
      act_q.field_len <= DEF_FIELD_LEN;
    end else if (commit_i && ctl_q.run && !ctl_q.hold) begin
      act_q <= stage_q;
    end
  end

  assign ctl_o = ctl_q;
  assign act_o = act_q;

  // R4
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.hold |=> $stable(act_q));

  // R5
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_q));
endmodule

// File: rtl/vts_tgen_core.sv
module vts_tgen_core
  import vts_pkg::*;
#(
  parameter int HRST_LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] field_len,
  input  logic [2:0]    in_cur,
  input  logic [2:0]    in_prev,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic          commit_o,
  output logic          susp_o
);
  localparam int DW = (HRST_LAT > 2) ? $clog2(HRST_LAT - 1) : 1;
  localparam logic [DW-1:0] DLY_LOAD = DW'(HRST_LAT - 2);
  localparam int I_SYNC = 0;
  localparam int I_VD   = 1;
  localparam int I_HD   = 2;

  logic [2:0]    fall, rise;
  logic          h_wrap, msync;
  logic [CW-1:0] h_q, v_q;
  logic          armed_q, dly_act_q, susp_q;
  logic [DW-1:0] dly_q;

  assign fall   = in_prev & ~in_cur;
  assign rise   = ~in_prev & in_cur;
  assign h_wrap = (h_q >= line_len);
  assign msync  = ctl.sync_en && !ctl.slave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q       <= '0;
      v_q       <= '0;
      armed_q   <= 1'b0;
      dly_act_q <= 1'b0;
      dly_q     <= '0;
    end else if (!ctl.run) begin
      h_q       <= '0;
      v_q       <= '0;
      armed_q   <= 1'b0;
      dly_act_q <= 1'b0;
    end else begin
      if (h_wrap) begin
        h_q <= '0;
        v_q <= (v_q >= field_len) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
      if (dly_act_q) begin
        if (dly_q == '0) begin
          dly_act_q <= 1'b0;
          h_q       <= '0;
          v_q       <= '0;
        end else begin
          dly_q <= dly_q - 1'b1;
        end
      end
      if (ctl.slave) begin
        if (armed_q && fall[I_HD]) begin
          dly_act_q <= 1'b1;
          dly_q     <= DLY_LOAD;
          armed_q   <= 1'b0;
        end
        if (fall[I_VD]) armed_q <= 1'b1;
      end else begin
        armed_q   <= 1'b0;
        dly_act_q <= 1'b0;
      end
      if (msync && rise[I_SYNC]) begin
        h_q <= '0;
        v_q <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                susp_q <= 1'b0;
    else if (!ctl.run || !msync || !ctl.susp_en) susp_q <= 1'b0;
    else if (fall[I_SYNC])                     susp_q <= 1'b1;
    else if (rise[I_SYNC])                     susp_q <= 1'b0;
  end

  assign commit_o = ctl.run && (ctl.slave ? fall[I_HD] : h_wrap);
  assign h_cnt    = h_q;
  assign v_cnt    = v_q;
  assign susp_o   = susp_q;

  // R1
  core_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |=> (h_q == '0 && v_q == '0));

  // R8
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && msync && rise[I_SYNC]) |=> (h_q == '0 && v_q == '0));

  // R9
  susp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.sync_en |=> !susp_q);

  // R10
  slave_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && ctl.slave && armed_q && fall[I_HD]) |=> dly_act_q);
endmodule

// File: rtl/vtiming_shadow_ctl.sv
module vtiming_shadow_ctl
  import vts_pkg::*;
#(
  parameter logic [11:0] DEF_LINE_LEN  = 12'd799,
  parameter logic [11:0] DEF_FIELD_LEN = 12'd524,
  parameter int          HRST_LAT      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  input  logic [2:0]  cfg_addr,
  input  logic [11:0] cfg_data,
  input  logic        sync_in,
  input  logic        vd_in,
  input  logic        hd_in,
  output logic        act_out_en,
  output logic [11:0] act_line_len,
  output logic [11:0] act_field_len,
  output logic [11:0] h_cnt,
  output logic [11:0] v_cnt,
  output logic        clk_gate_en
);
  ctl_t       ctl;
  vcfg_t      act;
  logic [2:0] in_cur, in_prev;
  logic       commit, susp;

  assign cfg_ready = 1'b1;

  vts_in_sync #(.N(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({hd_in, vd_in, sync_in}),
    .cur_o   (in_cur),
    .prev_o  (in_prev)
  );

  vts_cfg_bank #(
    .DEF_LINE_LEN  (DEF_LINE_LEN),
    .DEF_FIELD_LEN (DEF_FIELD_LEN)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_valid && cfg_ready),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .commit_i (commit),
    .ctl_o    (ctl),
    .act_o    (act)
  );

  vts_tgen_core #(.HRST_LAT(HRST_LAT)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .line_len  (act.line_len),
    .field_len (act.field_len),
    .in_cur    (in_cur),
    .in_prev   (in_prev),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .commit_o  (commit),
    .susp_o    (susp)
  );

  assign act_out_en    = act.out_en;
  assign act_line_len  = act.line_len;
  assign act_field_len = act.field_len;
  assign clk_gate_en   = act.out_en && ctl.run && !susp;

  // R6
  outen_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_out_en) |-> $past(commit));
endmodule

// File: tb/vtiming_shadow_ctl_tb.sv
module vtiming_shadow_ctl_tb;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [2:0]  cfg_addr = '0;
  logic [11:0] cfg_data = '0;
  logic        sync_in = 1'b1, vd_in = 1'b1, hd_in = 1'b1;
  logic        act_out_en, clk_gate_en;
  logic [11:0] act_line_len, act_field_len, h_cnt, v_cnt;

  always #10 clk = ~clk;

  vtiming_shadow_ctl #(.DEF_LINE_LEN(12'd39), .DEF_FIELD_LEN(12'd9), .HRST_LAT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sync_in(sync_in), .vd_in(vd_in),
    .hd_in(hd_in), .act_out_en(act_out_en), .act_line_len(act_line_len),
    .act_field_len(act_field_len), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .clk_gate_en(clk_gate_en)
  );

  localparam int S_H = 0, S_V = 1, S_GATE = 2, S_LINE = 3, S_OUTEN = 4, S_RDY = 5;

  typedef struct {
    int    due;
    int    sel;
    int    val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int probe(int sel);
    case (sel)
      S_H:     return int'(h_cnt);
      S_V:     return int'(v_cnt);
      S_GATE:  return int'(clk_gate_en);
      S_LINE:  return int'(act_line_len);
      S_OUTEN: return int'(act_out_en);
      default: return int'(cfg_ready);
    endcase
  endfunction

  task automatic expect_at(int due, int sel, int val, string req);
    exp_t e;
    e.due = due; e.sel = sel; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        int act_v;
        act_v = probe(q[i].sel);
        checks++;
        if (act_v != q[i].val) begin
          errors++;
          $display("FAIL %s cyc=%0d sel=%0d actual=%0d expected=%0d",
                   q[i].req, cyc, q[i].sel, act_v, q[i].val);
        end
        q.delete(i);
      end
    end
    if (cyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [2:0] a, logic [11:0] d);
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_until(int x);
    while (cyc < x) @(negedge clk);
  endtask

  int cP, base, c, d, t, t2, k, k3, p;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 reset state
    expect_at(cyc + 1, S_H, 0, "R1");
    expect_at(cyc + 1, S_V, 0, "R1");
    expect_at(cyc + 1, S_GATE, 0, "R1");
    expect_at(cyc + 1, S_LINE, 39, "R3");
    expect_at(cyc + 1, S_RDY, 1, "R3");
    repeat (3) @(negedge clk);

    // R2 counting and wrap
    wr(3'd0, 12'd1);
    cP = cyc;
    expect_at(cP + 39, S_H, 39, "R2");
    expect_at(cP + 40, S_H, 0, "R2");
    expect_at(cP + 40, S_V, 1, "R2");
    expect_at(cP + 399, S_V, 9, "R2");
    expect_at(cP + 400, S_V, 0, "R2");

    // R4 inhibit blocks commits
    wr(3'd1, 12'd1);
    wr(3'd5, 12'd19);
    expect_at(cyc + 100, S_LINE, 39, "R4");
    wait_until(cP + 410);

    // R5 commit at next wrap
    wr(3'd1, 12'd0);
    c = cyc; d = 40 - ((c - cP) % 40);
    expect_at(c + d - 1, S_LINE, 39, "R5");
    expect_at(c + d, S_LINE, 19, "R5");
    expect_at(c + d, S_H, 0, "R5");
    wait_until(c + d + 1);
    base = c + d;

    // R6 output enable only after commit
    wr(3'd4, 12'd1);
    c = cyc; d = 20 - ((c - base) % 20);
    expect_at(c + d - 1, S_GATE, 0, "R6");
    expect_at(c + d, S_GATE, 1, "R6");
    expect_at(c + d, S_OUTEN, 1, "R6");
    wait_until(c + d + 2);

    // R7 sync ignored while disabled
    wr(3'd3, 12'd1);
    sync_in = 1'b0; t = cyc;
    expect_at(t + 4, S_GATE, 1, "R7");
    expect_at(t + 8, S_GATE, 1, "R7");
    expect_at(t + 8, S_H, (t + 8 - base) % 20, "R7");
    repeat (5) @(negedge clk);
    sync_in = 1'b1;
    wait_until(t + 9);

    // R8 R9 sync with suspend
    wr(3'd2, 12'd1);
    sync_in = 1'b0; t = cyc;
    expect_at(t + 2, S_GATE, 1, "R9");
    expect_at(t + 3, S_GATE, 0, "R9");
    repeat (6) @(negedge clk);
    sync_in = 1'b1; t2 = cyc;
    expect_at(t2 + 2, S_GATE, 0, "R9");
    expect_at(t2 + 3, S_GATE, 1, "R9");
    expect_at(t2 + 2, S_H, (t2 + 2 - base) % 20, "R8");
    expect_at(t2 + 3, S_H, 0, "R8");
    expect_at(t2 + 3, S_V, 0, "R8");
    wait_until(t2 + 4);
    base = t2 + 3;

    // R9 suspend off: gate stays, R8 reset still happens
    wr(3'd3, 12'd0);
    sync_in = 1'b0; t = cyc;
    expect_at(t + 3, S_GATE, 1, "R9");
    expect_at(t + 5, S_GATE, 1, "R9");
    repeat (6) @(negedge clk);
    sync_in = 1'b1;
    expect_at(t + 9, S_H, 0, "R8");
    wait_until(t + 10);
    base = t + 9;

    // R10 slave: unarmed HD does not reset
    wr(3'd7, 12'd1);
    hd_in = 1'b0; k = cyc;
    expect_at(k + 10, S_H, (k + 10 - base) % 20, "R10");
    repeat (4) @(negedge clk);
    hd_in = 1'b1;
    wait_until(k + 11);

    // R10 slave: armed by VD, reset 10 edges after HD
    vd_in = 1'b0;
    repeat (4) @(negedge clk);
    vd_in = 1'b1;
    repeat (2) @(negedge clk);
    hd_in = 1'b0; k3 = cyc;
    expect_at(k3 + 9, S_H, (k3 + 9 - base) % 20, "R10");
    expect_at(k3 + 10, S_H, 0, "R10");
    expect_at(k3 + 10, S_V, 0, "R10");
    repeat (4) @(negedge clk);
    hd_in = 1'b1;
    wait_until(k3 + 11);

    // R11 slave commit on HD only
    wr(3'd5, 12'd29);
    c = cyc;
    expect_at(c + 25, S_LINE, 19, "R11");
    wait_until(c + 26);
    hd_in = 1'b0; k = cyc;
    expect_at(k + 2, S_LINE, 19, "R11");
    expect_at(k + 3, S_LINE, 29, "R11");
    repeat (4) @(negedge clk);
    hd_in = 1'b1;
    wait_until(k + 5);

    // R1 stop: counters held, no commit
    wr(3'd0, 12'd0);
    p = cyc;
    expect_at(p + 1, S_H, 0, "R1");
    expect_at(p + 1, S_V, 0, "R1");
    expect_at(p + 1, S_GATE, 0, "R1");
    expect_at(p + 6, S_H, 0, "R1");
    wr(3'd5, 12'd5);
    hd_in = 1'b0; k = cyc;
    expect_at(k + 5, S_LINE, 29, "R1");
    repeat (4) @(negedge clk);
    hd_in = 1'b1;

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule